// File: doc/BRIEF.md
# DMA Request Mapper and Interrupt Aggregator

This block sits between a bank of peripheral DMA request lines and a smaller set of DMA channels. Each request line has its own mapping register. The register holds an enable flag and the number of a target channel. Every enabled request is forwarded, in the same cycle, to the request input of the channel it names. A request whose entry is not enabled reaches no channel. When several enabled requests point at one channel, that channel sees the OR of them.

In the other direction, the block gathers the per-channel interrupt lines into one summary register, with one bit per channel. It drives a single interrupt output that is high while any summary bit is set. Software reads the summary and writes the same value back to clear the bits it has serviced. A channel whose interrupt line is still high sets its bit again on the cycle after the clear.

All registers sit behind a simple single-cycle port: an address, a write strobe and write data, plus read data that follows the address combinationally. The asynchronous reset is applied at once and is released through a two-stage synchronizer.

Top module: `dma_req_mapper`

## Requirements
- R1: After reset every mapping register and the summary register read zero, `irq_out` is low and `ch_req` is all zero.
- R2: A write to address r (0 to NUM_REQ-1) stores data bit 7 as the enable flag and data bits 3:0 as the channel. A read of address r returns the enable in bit 7 and the channel in bits 3:0, with all other bits zero.
- R3: When request r is high and its entry is enabled, `ch_req` bit `chan` is high in the same cycle. A channel that no high, enabled request points at stays low.
- R4: A channel targeted by several enabled requests is high when any one of them is high.
- R5: An entry whose enable bit is zero routes its request to no channel, whatever its channel field holds. A value of zero disconnects the request.
- R6: Summary bit i, read at address 64, becomes set on the cycle after `ch_irq[i]` is sampled high on a clock edge. It then stays set until it is cleared.
- R7: A write to address 64 clears every summary bit whose data bit is 1 and leaves the bits written with 0 unchanged. In the clearing cycle the clear wins over a new interrupt, and a still-high `ch_irq[i]` sets the bit again one cycle later.
- R8: `irq_out` is high exactly when some summary bit is set.
- R9: Addresses that are neither a mapping register nor the summary read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 7 | Register word address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| periph_req | input | 40 | Peripheral request lines |
| ch_req | output | 16 | Forwarded request, one per channel |
| ch_irq | input | 16 | Per-channel interrupt lines |
| irq_out | output | 1 | Combined interrupt, high while any summary bit is set |

## Verification
The hardest case to reach from the ports is a clear of the summary that lands in the same cycle as a channel interrupt which is still high. The clear has to win in that cycle and the bit has to come back one cycle later. The stimulus holds one interrupt line high across a write-back and reads the summary in the cycles around it. A long random phase then mixes clears, new interrupts and remapping, so that overlaps of a clear with a rising line, and of several requests on one channel, happen many times over. A behavioural model compares every output on every cycle.

// File: rtl/dma_req_mapper_pkg.sv
package dma_req_mapper_pkg;

  // Channel field width of a mapping entry; enable sits at bit ENABLE_BIT.
  localparam int MAP_CH_W   = 4;
  localparam int ENABLE_BIT = 7;

  typedef struct packed {
    logic                valid;
    logic [MAP_CH_W-1:0] chan;
  } map_entry_t;

endpackage

// File: rtl/dma_req_mapper_rst_sync.sv
module dma_req_mapper_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/dma_req_mapper_map_regs.sv
module dma_req_mapper_map_regs
  import dma_req_mapper_pkg::*;
#(
  parameter int NUM_REQ = 40,
  parameter int ADDR_W  = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic                       wr_valid,
  input  logic [MAP_CH_W-1:0]        wr_chan,
  output map_entry_t [NUM_REQ-1:0]   entries_o
);

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_entry
    logic       hit;
    map_entry_t ent_d;
    map_entry_t ent_q;

    assign hit = wr_en && (wr_addr == ADDR_W'(r));

    always_comb begin
      ent_d = ent_q;
      if (hit) begin
        ent_d.valid = wr_valid;
        ent_d.chan  = wr_chan;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (hit) begin
        ent_q <= ent_d;
      end
    end

    assign entries_o[r] = ent_q;
  end

endmodule

// File: rtl/dma_req_mapper_router.sv
module dma_req_mapper_router
  import dma_req_mapper_pkg::*;
#(
  parameter int NUM_REQ = 40,
  parameter int NUM_CH  = 16
) (
  input  map_entry_t [NUM_REQ-1:0] entries_i,
  input  logic [NUM_REQ-1:0]       req_i,
  output logic [NUM_CH-1:0]        ch_req_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_comb begin
      ch_req_o[c] = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (req_i[r] && entries_i[r].valid && (entries_i[r].chan == MAP_CH_W'(c))) begin
          ch_req_o[c] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dma_req_mapper_irq_sum.sv
module dma_req_mapper_irq_sum #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_irq_i,
  input  logic              ack_en,
  input  logic [NUM_CH-1:0] ack_mask,
  output logic [NUM_CH-1:0] sum_o
);

  logic [NUM_CH-1:0] sum_d;
  logic [NUM_CH-1:0] sum_q;
  logic [NUM_CH-1:0] clr;
  logic              sum_en;

  always_comb begin
    clr    = ack_en ? ack_mask : '0;
    sum_en = ack_en || (ch_irq_i != '0);
    sum_d  = (sum_q | ch_irq_i) & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/dma_req_mapper.sv
module dma_req_mapper
  import dma_req_mapper_pkg::*;
#(
  parameter int NUM_REQ = 40,
  parameter int NUM_CH  = 16,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_REQ-1:0] periph_req,
  output logic [NUM_CH-1:0] ch_req,
  input  logic [NUM_CH-1:0] ch_irq,
  output logic              irq_out
);

  localparam logic [ADDR_W-1:0] SUM_ADDR = ADDR_W'(1) << (ADDR_W - 1);

  logic                     rst_n_sync;
  map_entry_t [NUM_REQ-1:0] entries;
  logic [NUM_CH-1:0]        sum_q;
  logic                     ack_en;
  logic                     wdata_unused;

  assign ack_en       = reg_wr && (reg_addr == SUM_ADDR);
  assign wdata_unused = ^reg_wdata[DATA_W-1:NUM_CH];

  dma_req_mapper_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dma_req_mapper_map_regs #(
    .NUM_REQ (NUM_REQ),
    .ADDR_W  (ADDR_W)
  ) u_map_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_en     (reg_wr),
    .wr_addr   (reg_addr),
    .wr_valid  (reg_wdata[ENABLE_BIT]),
    .wr_chan   (reg_wdata[MAP_CH_W-1:0]),
    .entries_o (entries)
  );

  dma_req_mapper_router #(
    .NUM_REQ (NUM_REQ),
    .NUM_CH  (NUM_CH)
  ) u_router (
    .entries_i (entries),
    .req_i     (periph_req),
    .ch_req_o  (ch_req)
  );

  dma_req_mapper_irq_sum #(
    .NUM_CH (NUM_CH)
  ) u_irq_sum (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .ch_irq_i (ch_irq),
    .ack_en   (ack_en),
    .ack_mask (reg_wdata[NUM_CH-1:0]),
    .sum_o    (sum_q)
  );

  assign irq_out = |sum_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == SUM_ADDR) begin
      reg_rdata = DATA_W'(sum_q);
    end
    for (int r = 0; r < NUM_REQ; r++) begin
      if (reg_addr == ADDR_W'(r)) begin
        reg_rdata[ENABLE_BIT]     = entries[r].valid;
        reg_rdata[MAP_CH_W-1:0]   = entries[r].chan;
      end
    end
  end

endmodule

// File: rtl/dma_req_mapper_chk.sv
module dma_req_mapper_chk #(
  parameter int NUM_REQ = 40,
  parameter int NUM_CH  = 16,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n_sync,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [NUM_REQ-1:0] periph_req,
  input logic [NUM_CH-1:0]  ch_req,
  input logic [NUM_CH-1:0]  ch_irq,
  input logic               irq_out,
  input logic [NUM_CH-1:0]  sum_q
);

  localparam logic [ADDR_W-1:0] SUM_ADDR = ADDR_W'(1) << (ADDR_W - 1);

  logic              ack;
  logic [NUM_CH-1:0] ack_bits;

  assign ack      = reg_wr && (reg_addr == SUM_ADDR);
  assign ack_bits = reg_wdata[NUM_CH-1:0];

  AST_IDLE_NO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (periph_req == '0) |-> (ch_req == '0)); // R3

  AST_MAP_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (reg_addr < ADDR_W'(NUM_REQ)) |-> (reg_rdata[DATA_W-1:8] == '0 && reg_rdata[6:4] == 3'b000)); // R2

  AST_SUM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!ack) |=> ((sum_q & $past(ch_irq)) == $past(ch_irq))); // R6

  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!ack) |=> ((sum_q & $past(sum_q)) == $past(sum_q))); // R6

  AST_SUM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ((sum_q & ~$past(sum_q) & ~$past(ch_irq)) == '0)); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ack |=> ((sum_q & $past(ack_bits)) == '0)); // R7

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(irq_out) |-> ($past(ch_irq) != '0)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ((reg_addr >= ADDR_W'(NUM_REQ)) && (reg_addr != SUM_ADDR)) |-> (reg_rdata == '0)); // R9

endmodule

bind dma_req_mapper dma_req_mapper_chk #(
  .NUM_REQ (NUM_REQ),
  .NUM_CH  (NUM_CH),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) chk_i (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .periph_req (periph_req),
  .ch_req     (ch_req),
  .ch_irq     (ch_irq),
  .irq_out    (irq_out),
  .sum_q      (sum_q)
);

// File: tb/dma_req_mapper_tb_top.sv
`timescale 1ns/1ps
module dma_req_mapper_tb_top;

  localparam int NREQ = 40;
  localparam int NCH  = 16;
  localparam int SUMA = 64;

  logic        clk;
  logic        rst_n;
  logic [6:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [39:0] periph_req;
  logic [15:0] ch_req;
  logic [15:0] ch_irq;
  logic        irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural reference state
  bit       m_en  [NREQ];
  bit [3:0] m_ch  [NREQ];
  bit [15:0] m_sum;

  dma_req_mapper dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .periph_req (periph_req),
    .ch_req     (ch_req),
    .ch_irq     (ch_irq),
    .irq_out    (irq_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_outputs(input string rtag);
    logic [15:0] exp_req;
    logic [31:0] exp_rd;
    string       rd_tag;
    exp_req = '0;
    for (int r = 0; r < NREQ; r++)
      if (m_en[r] && periph_req[r]) exp_req[m_ch[r]] = 1'b1;
    exp_rd = '0;
    if (reg_addr < NREQ) begin
      exp_rd[7]   = m_en[reg_addr];
      exp_rd[3:0] = m_ch[reg_addr];
      rd_tag = "R2 map readback";
    end else if (reg_addr == SUMA) begin
      exp_rd[15:0] = m_sum;
      rd_tag = "R6/R7 summary";
    end else begin
      rd_tag = "R9 unmapped read";
    end
    if (rtag.len() != 0) rd_tag = rtag;
    check("R3/R4/R5 ch_req", {24'b0, ch_req}, {24'b0, exp_req});
    check(rd_tag, {8'b0, reg_rdata}, {8'b0, exp_rd});
    check("R8 irq_out", {39'b0, irq_out}, {39'b0, (m_sum != 0)});
  endtask

  task automatic step(input logic [6:0] a, input logic w, input logic [31:0] d,
                      input logic [39:0] pr, input logic [15:0] ci, input string rtag = "");
    logic [15:0] ack;
    @(negedge clk);
    reg_addr = a; reg_wr = w; reg_wdata = d; periph_req = pr; ch_irq = ci;
    #1;
    compare_outputs(rtag);
    @(posedge clk);
    ack = '0;
    if (w) begin
      if (a < NREQ) begin
        m_en[a] = d[7];
        m_ch[a] = d[3:0];
      end else if (a == SUMA) begin
        ack = d[15:0];
      end
    end
    m_sum = (m_sum | ci) & ~ack;
  endtask

  task automatic summary_line();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary_line();
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREQ; r++) begin m_en[r] = 0; m_ch[r] = 0; end
    m_sum = '0;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 0; reg_wdata = '0; periph_req = '0; ch_irq = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state during reset
    check("R1 ch_req in reset", {24'b0, ch_req}, 40'd0);
    check("R1 irq_out in reset", {39'b0, irq_out}, 40'd0);
    check("R1 map0 in reset", {8'b0, reg_rdata}, 40'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(7'd0, 0, '0, '0, '0, "R1 idle");

    // R1: every address reads zero after reset
    for (int a = 0; a < 128; a++) step(7'(a), 0, '0, '0, '0, "R1 reset readback");

    // R2: program entries with reserved bits set; entry r -> channel r%16
    for (int r = 0; r < NREQ; r++) step(7'(r), 1, 32'hFFFF_FFF0 | 32'(r % NCH), '0, '0);
    for (int r = 0; r < NREQ; r++) step(7'(r), 0, '0, '0, '0);

    // R3: one request at a time
    for (int r = 0; r < NREQ; r++) step(7'd0, 0, '0, 40'd1 << r, '0);
    // R4: several requests sharing channels
    step(7'd0, 0, '0, (40'd1 << 3) | (40'd1 << 19) | (40'd1 << 35), '0);
    step(7'd0, 0, '0, 40'hFF_FFFF_FFFF, '0);
    step(7'd0, 0, '0, 40'hAA_0000_5555, '0);

    // R5: disabled entry with nonzero channel, and an all-zero entry
    step(7'd5, 1, 32'h0000_000C, '0, '0);
    step(7'd6, 1, 32'h0000_0000, '0, '0);
    step(7'd5, 0, '0, 40'd1 << 5, '0);
    step(7'd6, 0, '0, 40'd1 << 6, '0);
    step(7'd0, 0, '0, (40'd1 << 5) | (40'd1 << 6), '0);

    // R9: writes to unmapped addresses change nothing
    step(7'd50, 1, 32'hFFFF_FFFF, '0, '0);
    step(7'd127, 1, 32'hFFFF_FFFF, '0, '0);
    step(7'd50, 0, '0, '0, '0);
    for (int r = 0; r < NREQ; r++) step(7'(r), 0, '0, 40'd1 << r, '0);

    // R6: capture and hold
    step(7'(SUMA), 0, '0, '0, 16'h0005);
    repeat (3) step(7'(SUMA), 0, '0, '0, '0);
    // R7: partial clear, zero write leaves bits
    step(7'(SUMA), 1, 32'h0000_0001, '0, '0);
    step(7'(SUMA), 1, 32'h0000_0000, '0, '0);
    step(7'(SUMA), 0, '0, '0, '0);
    // R7: clear while line still high: cleared, then set again
    step(7'(SUMA), 0, '0, '0, 16'h0008);
    step(7'(SUMA), 1, 32'h0000_000C, '0, 16'h0008);
    step(7'(SUMA), 0, '0, '0, 16'h0008);
    step(7'(SUMA), 0, '0, '0, '0);
    step(7'(SUMA), 1, 32'h0000_FFFF, '0, '0);
    step(7'(SUMA), 0, '0, '0, '0);

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] rq;
      logic [31:0] op, dat;
      logic [15:0] irq;
      rq  = {$urandom(), $urandom()};
      op  = $urandom() % 8;
      dat = $urandom();
      irq = 16'($urandom() & $urandom() & $urandom());
      if (op < 2)       step(7'($urandom() % NREQ), 1, dat, rq[39:0], irq);
      else if (op == 2) step(7'(SUMA), 1, dat, rq[39:0], irq);
      else if (op == 3) step(7'($urandom() % 128), 1, dat, rq[39:0], irq);
      else if (op == 4) step(7'(SUMA), 0, '0, rq[39:0], irq);
      else              step(7'($urandom() % 128), 0, '0, rq[39:0], irq);
    end

    done = 1;
    summary_line();
    $finish;
  end

endmodule